// File: doc/BRIEF.md
# Serial Tuning-Word Receiver

This block is the slave end of a three-wire serial link that sets a 32-step tuning element. A master opens a transfer by raising the enable line, then presents data bits that the block captures on each rising edge of the serial clock. The most significant bit comes first. The block does not count bits. It keeps a plain eight-bit shift register, so only the last eight bits received are retained. When enable falls, the retained word is copied into an active register. That register drives a five-bit tuning state and a standby control.

All three serial lines are oversampled by a system clock. Each passes through a two-flop synchronizer, and edges are detected on the synchronized levels. A small two-state machine tracks the transfer. In `ST_IDLE` (enable low) serial clock edges are ignored. The transition `ST_IDLE -> ST_FRAME` is taken when the synchronized enable is high. `ST_FRAME` shifts one bit per detected serial clock rise. The transition `ST_FRAME -> ST_IDLE` is taken when the synchronized enable is low, and it issues the load strobe. A one-cycle `word_applied` pulse marks each load.

Top module: `tune_word_rx`

## Requirements
- R1: After reset, `tune_state` is 0, `standby` is 0, `word_applied` is 0 and the shift register holds all zeros.
- R2: While enable is high, each rising serial clock edge shifts the data bit into bit 0 of the shift register, so the first bit sent ends up in bit 7 (MSB first).
- R3: When more than eight bits are sent in one transfer, only the last eight received are kept.
- R4: The active outputs change only on a falling edge of enable. During a transfer they hold their previous value.
- R5: Word bit 5 drives `standby`: 1 selects standby and 0 selects the active mode.
- R6: Word bits 4..0 drive `tune_state` (0 to 31). Word bits 7 and 6 have no effect on any output.
- R7: Serial clock edges that occur while enable is low do not alter the shift register.
- R8: A transfer of fewer than eight bits, including one of zero bits, loads the current shift register. That value still holds bits from earlier transfers.
- R9: `word_applied` is high for exactly one system clock cycle for each falling edge of enable.
- R10: The new outputs are visible no later than three system clock cycles after enable is driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Serial enable; high frames a transfer |
| ser_clk | input | 1 | Serial clock; data is captured on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| tune_state | output | 5 | Active tuning state |
| standby | output | 1 | Active standby control (1 = standby) |
| word_applied | output | 1 | One-cycle pulse when a word is loaded |

## Verification
Several frame patterns are used, and each one separates a different kind of fault.
- Exact eight-bit frames with known values show whether the bit order and the field positions are correct.
- Frames with reserved bits set confirm that bits 7 and 6 are dropped.
- Over-length frames show whether the oldest bits are discarded rather than the newest.
- Short and empty frames, sent after serial-clock toggling with enable low, show whether idle edges leak into the register and whether stale bits survive.
- Seeded random frames of 0 to 12 bits, mixed with idle noise, are checked against a bench shift model for both outputs and for the count of load pulses.

// File: rtl/tune_word_pkg.sv
package tune_word_pkg;
    localparam int WORD_W      = 8;
    localparam int TUNE_W      = 5;
    localparam int STBY_POS    = 5;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FRAME = 1'b1
    } rx_state_e;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int LANES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw,
    output logic [LANES-1:0] level,
    output logic [LANES-1:0] rise,
    output logic [LANES-1:0] fall
);
    localparam int CHAIN_W = STAGES + 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CHAIN_W-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[CHAIN_W-2:0], raw[g]};
            end
        end

        assign level[g] = chain[STAGES-1];
        assign rise[g]  = chain[STAGES-1] & ~chain[STAGES];
        assign fall[g]  = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/tune_frame_fsm.sv
module tune_frame_fsm
    import tune_word_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_lvl,
    input  logic         sclk_rise,
    input  logic         dat_lvl,
    output logic         load,
    output logic [W-1:0] shift_q
);
    rx_state_e state_q, state_d;
    logic      shift_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        shift_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en_lvl) begin
                    state_d = ST_FRAME;
                end
            end
            ST_FRAME: begin
                if (!en_lvl) begin
                    state_d = ST_IDLE;
                    load    = 1'b1;
                end else begin
                    shift_en = sclk_rise;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (shift_en) begin
            shift_q <= {shift_q[W-2:0], dat_lvl};
        end
    end

    assert_idle_no_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(shift_q))
        else $error("shift register moved while idle");

    assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FRAME && en_lvl && sclk_rise) |=>
        (shift_q[0] == $past(dat_lvl) && shift_q[W-1:1] == $past(shift_q[W-2:0])))
        else $error("bit not shifted in at LSB");

    assert_load_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load)
        else $error("load strobe wider than one cycle");
endmodule

// File: rtl/tune_hold_reg.sv
module tune_hold_reg
    import tune_word_pkg::*;
#(
    parameter int W    = WORD_W,
    parameter int TW   = TUNE_W,
    parameter int SPOS = STBY_POS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  word_in,
    output logic [TW-1:0] tune_q,
    output logic          stby_q,
    output logic          applied_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tune_q    <= '0;
            stby_q    <= 1'b0;
            applied_q <= 1'b0;
        end else begin
            applied_q <= load;
            if (load) begin
                tune_q <= word_in[TW-1:0];
                stby_q <= word_in[SPOS];
            end
        end
    end

    assert_hold_between_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({stby_q, tune_q}))
        else $error("active word changed without load");

    assert_tune_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (tune_q == $past(word_in[TW-1:0])))
        else $error("tuning field mismatch");

    assert_standby_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (stby_q == $past(word_in[SPOS])))
        else $error("standby bit mismatch");

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        applied_q |=> !applied_q)
        else $error("applied pulse too long");
endmodule

// File: rtl/tune_word_rx.sv
module tune_word_rx
    import tune_word_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int TW     = TUNE_W,
    parameter int SPOS   = STBY_POS,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_en,
    input  logic          ser_clk,
    input  logic          ser_dat,
    output logic [TW-1:0] tune_state,
    output logic          standby,
    output logic          word_applied
);
    localparam int LANES = 3;
    localparam int L_EN  = 0;
    localparam int L_CLK = 1;
    localparam int L_DAT = 2;

    logic [LANES-1:0] raw, lvl, rise, fall;
    logic             load;
    logic [W-1:0]     shift_q;

    assign raw = {ser_dat, ser_clk, ser_en};

    ser_sync #(.LANES(LANES), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw),
        .level (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    tune_frame_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_lvl    (lvl[L_EN]),
        .sclk_rise (rise[L_CLK]),
        .dat_lvl   (lvl[L_DAT]),
        .load      (load),
        .shift_q   (shift_q)
    );

    tune_hold_reg #(.W(W), .TW(TW), .SPOS(SPOS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .word_in   (shift_q),
        .tune_q    (tune_state),
        .stby_q    (standby),
        .applied_q (word_applied)
    );

    assert_load_on_en_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> fall[L_EN] || !lvl[L_EN])
        else $error("load without enable low");

    assert_applied_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        word_applied |-> !lvl[L_EN] && !ser_sync_unused(rise[L_EN]))
        else $error("applied while enable high");

    function automatic logic ser_sync_unused(input logic v);
        return v;
    endfunction
endmodule

// File: tb/sim_tune_word_rx.sv
`timescale 1ns/1ps
module sim_tune_word_rx;
    localparam int HP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_en = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic [4:0] tune_state;
    logic       standby;
    logic       word_applied;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int frames = 0;
    logic [7:0] model_sr = 8'h00;
    logic [7:0] model_act = 8'h00;

    always #2.5 clk = ~clk;

    tune_word_rx u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_en       (ser_en),
        .ser_clk      (ser_clk),
        .ser_dat      (ser_dat),
        .tune_state   (tune_state),
        .standby      (standby),
        .word_applied (word_applied)
    );

    always @(posedge clk) if (rst_n && word_applied) pulses <= pulses + 1;

    function automatic logic [4:0] exp_tune(input logic [7:0] w);
        return w[4:0];
    endfunction

    function automatic logic exp_stby(input logic [7:0] w);
        return w[5];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_noise(input int n);
        for (int i = 0; i < n; i++) begin
            ser_dat = 1'($urandom);
            wait_n(HP);
            ser_clk = 1'b1;
            wait_n(HP);
            ser_clk = 1'b0;
        end
        wait_n(HP);
    endtask

    task automatic send_frame(input int nbits, input logic [15:0] bits, input string req);
        @(negedge clk);
        ser_en = 1'b1;
        wait_n(HP);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            wait_n(HP);
            ser_clk = 1'b1;
            model_sr = {model_sr[6:0], bits[i]};
            wait_n(HP);
            ser_clk = 1'b0;
        end
        wait_n(HP);
        // R4: outputs unchanged during the transfer
        chk({req, " R4 hold tune"}, tune_state, exp_tune(model_act));
        chk({req, " R4 hold stby"}, standby, exp_stby(model_act));
        ser_en = 1'b0;
        model_act = model_sr;
        frames++;
        wait_n(3);
        // R10: visible three cycles after enable low
        chk({req, " R10 tune"}, tune_state, exp_tune(model_act));
        chk({req, " R5 stby"}, standby, exp_stby(model_act));
        wait_n(3);
        chk({req, " R9 pulses"}, pulses, frames);
        wait_n(HP);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        wait_n(4);
        // R1 reset state
        chk("R1 tune", tune_state, 0);
        chk("R1 stby", standby, 0);
        chk("R1 applied", word_applied, 0);
        rst_n = 1'b1;
        wait_n(4);
        // R1 + R8: empty frame exposes the cleared shift register
        send_frame(0, 16'h0, "R1 R8 empty");
        chk("R1 empty tune", tune_state, 0);
        // R2, R5, R6: exact frame 0x2D -> tune 13, standby 1
        send_frame(8, 16'h002D, "R2");
        chk("R6 tune 13", tune_state, 13);
        chk("R5 stby 1", standby, 1);
        // R6: reserved bits set have no effect
        send_frame(8, 16'h00C7, "R6");
        chk("R6 reserved tune", tune_state, 7);
        chk("R6 reserved stby", standby, 0);
        // R3: 12 bits, last eight are 0x3F
        send_frame(12, 16'h0A3F, "R3");
        chk("R3 tune", tune_state, 31);
        chk("R3 stby", standby, 1);
        // R7: idle toggling, then empty frame reloads the same word
        idle_noise(6);
        send_frame(0, 16'h0, "R7");
        chk("R7 tune", tune_state, 31);
        // R8: three bits 010 on top of 0x3F -> 0xFA
        send_frame(3, 16'h0002, "R8");
        chk("R8 tune", tune_state, 26);
        chk("R8 stby", standby, 1);
        for (int f = 0; f < 50; f++) begin
            if (($urandom % 3) == 0) idle_noise(1 + ($urandom % 4));
            send_frame($urandom % 13, 16'($urandom), "random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule